// File: doc/BRIEF.md
# Management and Suspend Mode Controller

This block keeps track of which operating mode a processor core is in. The core can be in normal execution, in system-management execution, in an interrupt handler entered from either of those, or in a suspended state. A suspended state is entered in one of two ways: by a halt instruction, or by a low level on the hardware suspend-request line. The instruction decoder reports halt, interrupt-return, management-entry and resume instructions as one-cycle pulses. The block combines these pulses with the suspend-request, management-interrupt, NMI, INTR and interrupt-enable inputs to choose the next mode.

How the block leaves suspend, and which events it holds back, depends on how suspend was entered and on whether the core was in management mode at the time. Events that are held back are kept in one sticky bit per source. Once the core is back in normal mode, it takes them one per cycle: management interrupt first, then NMI, then INTR. The block does not execute instructions, save state or vector interrupts. It only sequences modes and holds pending events.

Top module: `smm_susp_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, mode_o is 0 (normal), susp_ack_no is 1 and pend_o is 0. Mode codes: 0 normal, 1 normal-ISR, 2 normal halt-suspend, 3 normal hardware-suspend, 4 management, 5 management-ISR, 6 management halt-suspend, 7 management hardware-suspend.
- R2: susp_ack_no is 0 exactly when mode_o is 2, 3, 6 or 7.
- R3: In mode 0 with nothing pending, a low smi_ni or a smint_i pulse moves to mode 4 on the next clock. A rsm_i pulse in mode 4 returns to mode 0.
- R4: The effect of halt_i depends on the mode. From mode 0 it moves to 2 and from mode 4 it moves to 6. When there is no halt, a low susp_ni moves from 0 to 3 and from 4 to 7. In mode 4, rsm_i takes precedence over halt_i, and halt_i takes precedence over susp_ni.
- R5: In mode 2, a low smi_ni moves to mode 4. It takes precedence over NMI and INTR.
- R6: In mode 2, nmi_i, or intr_i with if_i high, moves to mode 1, and iret_i in mode 1 returns to mode 0. Mode 6 moves to 5 under the same condition, and iret_i in mode 5 returns to mode 4.
- R7: In mode 3, a low smi_ni, nmi_i, and intr_i with if_i high set pend_o bits 0, 1 and 2. A high susp_ni leaves mode 3 for mode 0.
- R8: In modes 4 and 7, nmi_i and intr_i (with if_i high) set pend_o bits 1 and 2, but smi_ni does not set bit 0. A high susp_ni leaves mode 7 for mode 4. Pending bits stay set while the core is in management modes.
- R9: When if_i is low, intr_i neither sets pend_o bit 2 nor wakes mode 2.
- R10: Each pend_o bit is a single sticky flag. Further events for a source that is already pending are dropped, and the bit stays set until it is consumed.
- R11: In mode 0, pending events are handled one per clock, ahead of halt and suspend requests. Bit 0 moves to mode 4. Otherwise bit 1, and then bit 2, moves to mode 1. Each of these steps clears only the bit it consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| susp_ni | input | 1 | Hardware suspend request, active low |
| smi_ni | input | 1 | Management interrupt, active low |
| nmi_i | input | 1 | Non-maskable interrupt |
| intr_i | input | 1 | Maskable interrupt |
| if_i | input | 1 | Interrupt-enable flag |
| halt_i | input | 1 | Halt instruction pulse |
| iret_i | input | 1 | Interrupt-return instruction pulse |
| smint_i | input | 1 | Management-entry instruction pulse |
| rsm_i | input | 1 | Resume-from-management instruction pulse |
| mode_o | output | 3 | Current mode code (see R1) |
| susp_ack_no | output | 1 | Suspend acknowledge, active low |
| pend_o | output | 3 | Pending flags: bit 0 management, bit 1 NMI, bit 2 INTR |

## Verification
The assertions assume that instruction pulses arrive only in modes where the decoder could issue them. For example, iret_i is expected only in an ISR mode, and rsm_i only in a management mode. The assertions also assume that the asynchronous inputs are already synchronous to clk_i. The stimulus drives every input on the falling edge and holds each instruction pulse for exactly one cycle. In the sweeps, each mode is first reached by its legal entry path, so no instruction ever arrives in a mode that could not have produced it.

// File: rtl/smm_susp_pkg.sv
package smm_susp_pkg;
  localparam int unsigned EVT_N    = 3;
  localparam int unsigned EVT_SMI  = 0;
  localparam int unsigned EVT_NMI  = 1;
  localparam int unsigned EVT_INTR = 2;

  // bit2: management context, bit1: suspended
  typedef enum logic [2:0] {
    M_NORM     = 3'd0,
    M_NORM_ISR = 3'd1,
    M_NORM_HLT = 3'd2,
    M_NORM_HW  = 3'd3,
    M_SMM      = 3'd4,
    M_SMM_ISR  = 3'd5,
    M_SMM_HLT  = 3'd6,
    M_SMM_HW   = 3'd7
  } mode_e;
endpackage

// File: rtl/smm_pend_latch.sv
module smm_pend_latch #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q <= 1'b0;
      else if (clr_i[g])  pend_q <= 1'b0;
      else if (set_i[g])  pend_q <= 1'b1;
    end
    assign pend_o[g] = pend_q;

    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q && !clr_i[g]) |=> pend_q); // R10
    AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] |=> !pend_q); // R11
  end
endmodule

// File: rtl/smm_mode_fsm.sv
module smm_mode_fsm
  import smm_susp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             susp_ni,
  input  logic             smi_ni,
  input  logic             nmi_i,
  input  logic             intr_i,
  input  logic             if_i,
  input  logic             halt_i,
  input  logic             iret_i,
  input  logic             smint_i,
  input  logic             rsm_i,
  input  logic [EVT_N-1:0] pend_i,
  output mode_e            mode_o,
  output logic [EVT_N-1:0] set_o,
  output logic [EVT_N-1:0] consume_o
);
  localparam logic [EVT_N-1:0] SMM_MASK = ~(EVT_N'(1) << EVT_SMI);

  mode_e            mode_q, mode_d;
  logic [EVT_N-1:0] evt;

  always_comb begin
    evt           = '0;
    evt[EVT_SMI]  = ~smi_ni;
    evt[EVT_NMI]  = nmi_i;
    evt[EVT_INTR] = intr_i & if_i;
  end

  always_comb begin
    mode_d    = mode_q;
    set_o     = '0;
    consume_o = '0;
    unique case (mode_q)
      M_NORM: begin
        if (pend_i[EVT_SMI] || evt[EVT_SMI] || smint_i) begin
          mode_d             = M_SMM;
          consume_o[EVT_SMI] = pend_i[EVT_SMI];
        end else if (pend_i[EVT_NMI] || evt[EVT_NMI]) begin
          mode_d             = M_NORM_ISR;
          consume_o[EVT_NMI] = pend_i[EVT_NMI];
        end else if (pend_i[EVT_INTR] || evt[EVT_INTR]) begin
          mode_d              = M_NORM_ISR;
          consume_o[EVT_INTR] = pend_i[EVT_INTR];
        end else if (halt_i) begin
          mode_d = M_NORM_HLT;
        end else if (!susp_ni) begin
          mode_d = M_NORM_HW;
        end
      end
      M_NORM_ISR: if (iret_i) mode_d = M_NORM;
      M_NORM_HLT: begin
        if (evt[EVT_SMI])                         mode_d = M_SMM;
        else if (evt[EVT_NMI] || evt[EVT_INTR])   mode_d = M_NORM_ISR;
      end
      M_NORM_HW: begin
        set_o = evt;
        if (susp_ni) mode_d = M_NORM;
      end
      M_SMM: begin
        set_o = evt & SMM_MASK;
        if (rsm_i)         mode_d = M_NORM;
        else if (halt_i)   mode_d = M_SMM_HLT;
        else if (!susp_ni) mode_d = M_SMM_HW;
      end
      M_SMM_ISR: if (iret_i) mode_d = M_SMM;
      M_SMM_HLT: if (evt[EVT_NMI] || evt[EVT_INTR]) mode_d = M_SMM_ISR;
      M_SMM_HW: begin
        set_o = evt & SMM_MASK;
        if (susp_ni) mode_d = M_SMM;
      end
      default: mode_d = M_NORM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= M_NORM;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  AST_HLT_SMI_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_NORM_HLT && !smi_ni) |=> mode_q == M_SMM); // R5
  AST_HW_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_NORM_HW && susp_ni) |=> mode_q == M_NORM); // R7
  AST_SMM_HW_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SMM_HW && susp_ni) |=> mode_q == M_SMM); // R8
  AST_RSM_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SMM && rsm_i) |=> mode_q == M_NORM); // R3
  AST_IRET_SMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SMM_ISR && iret_i) |=> mode_q == M_SMM); // R6
  AST_PEND_SMI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_NORM && pend_i[EVT_SMI]) |=> mode_q == M_SMM); // R11
endmodule

// File: rtl/smm_susp_ctrl.sv
module smm_susp_ctrl
  import smm_susp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       susp_ni,
  input  logic       smi_ni,
  input  logic       nmi_i,
  input  logic       intr_i,
  input  logic       if_i,
  input  logic       halt_i,
  input  logic       iret_i,
  input  logic       smint_i,
  input  logic       rsm_i,
  output logic [2:0] mode_o,
  output logic       susp_ack_no,
  output logic [2:0] pend_o
);
  mode_e            mode;
  logic [EVT_N-1:0] set, consume, pend;

  smm_mode_fsm u_fsm (
    .clk_i, .rst_ni, .susp_ni, .smi_ni, .nmi_i, .intr_i, .if_i,
    .halt_i, .iret_i, .smint_i, .rsm_i,
    .pend_i    (pend),
    .mode_o    (mode),
    .set_o     (set),
    .consume_o (consume)
  );

  smm_pend_latch #(.N(EVT_N)) u_pend (
    .clk_i, .rst_ni,
    .set_i  (set),
    .clr_i  (consume),
    .pend_o (pend)
  );

  assign mode_o      = mode;
  assign pend_o      = pend;
  assign susp_ack_no = ~mode[1];

  AST_INTR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!if_i && !pend[EVT_INTR]) |=> !pend[EVT_INTR]); // R9
  AST_SMM_NO_SMI_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[2] && !pend[EVT_SMI]) |=> !pend[EVT_SMI]); // R8
endmodule

// File: tb/smm_susp_ctrl_tb.sv
`timescale 1ns/1ps
module smm_susp_ctrl_tb;
  logic clk = 0, rst_ni = 0;
  logic susp_ni, smi_ni, nmi_i, intr_i, if_i, halt_i, iret_i, smint_i, rsm_i;
  logic [2:0] mode_o, pend_o;
  logic susp_ack_no;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  smm_susp_ctrl u_dut (.*, .clk_i(clk));

  task automatic idle();
    susp_ni = 1; smi_ni = 1; nmi_i = 0; intr_i = 0; if_i = 1;
    halt_i = 0; iret_i = 0; smint_i = 0; rsm_i = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk_mode(input logic [2:0] exp, input string req);
    logic exp_ack;
    exp_ack = !(exp == 3'd2 || exp == 3'd3 || exp == 3'd6 || exp == 3'd7);
    checks++;
    if (mode_o !== exp) begin
      errors++;
      $display("FAIL %s mode actual %0d expected %0d", req, mode_o, exp);
    end
    checks++;
    if (susp_ack_no !== exp_ack) begin
      errors++;
      $display("FAIL R2 ack actual %0b expected %0b (mode %0d)", susp_ack_no, exp_ack, exp);
    end
  endtask

  task automatic chk_pend(input logic [2:0] exp, input string req);
    checks++;
    if (pend_o !== exp) begin
      errors++;
      $display("FAIL %s pend actual %b expected %b", req, pend_o, exp);
    end
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 0;
    cyc(); cyc();
    chk_mode(3'd0, "R1"); chk_pend(3'b000, "R1");
    rst_ni = 1;
    cyc();
    chk_mode(3'd0, "R1"); chk_pend(3'b000, "R1");
  endtask

  // drain pending from mode 0 using the priority model
  task automatic drain(input logic [2:0] p0);
    logic [2:0] p;
    p = p0;
    for (int k = 0; k < 4 && p != 0; k++) begin
      idle(); cyc();
      if (p[0]) begin
        p[0] = 0; chk_mode(3'd4, "R11"); chk_pend(p, "R11");
        rsm_i = 1; cyc(); rsm_i = 0; chk_mode(3'd0, "R3");
      end else begin
        if (p[1]) p[1] = 0; else p[2] = 0;
        chk_mode(3'd1, "R11"); chk_pend(p, "R11");
        iret_i = 1; cyc(); iret_i = 0; chk_mode(3'd0, "R6");
      end
    end
    chk_pend(3'b000, "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R3
    smi_ni = 0; cyc(); smi_ni = 1; chk_mode(3'd4, "R3");
    rsm_i = 1; cyc(); rsm_i = 0; chk_mode(3'd0, "R3");
    smint_i = 1; cyc(); smint_i = 0; chk_mode(3'd4, "R3");
    // R4 in mgmt: rsm over halt over suspend
    rsm_i = 1; halt_i = 1; susp_ni = 0; cyc(); idle(); chk_mode(3'd0, "R4");
    smint_i = 1; cyc(); smint_i = 0;
    halt_i = 1; susp_ni = 0; cyc(); idle(); chk_mode(3'd6, "R4");
    nmi_i = 1; cyc(); nmi_i = 0; chk_mode(3'd5, "R6");
    iret_i = 1; cyc(); iret_i = 0; chk_mode(3'd4, "R6");
    rsm_i = 1; cyc(); rsm_i = 0; chk_mode(3'd0, "R3");
    halt_i = 1; susp_ni = 0; cyc(); idle(); chk_mode(3'd2, "R4");
    smi_ni = 0; cyc(); idle(); chk_mode(3'd4, "R5");
    rsm_i = 1; cyc(); rsm_i = 0;

    // sweep: halt-suspend wakeups, R5 R6 R9
    for (int c = 0; c < 16; c++) begin
      logic [2:0] exp;
      do_reset();
      halt_i = 1; cyc(); halt_i = 0; chk_mode(3'd2, "R4");
      smi_ni = !c[0]; nmi_i = c[1]; intr_i = c[2]; if_i = c[3];
      cyc(); idle();
      exp = c[0] ? 3'd4 : (c[1] || (c[2] && c[3])) ? 3'd1 : 3'd2;
      chk_mode(exp, c[0] ? "R5" : (c[2] && !c[3] && !c[1]) ? "R9" : "R6");
      chk_pend(3'b000, "R9");
    end

    // sweep: hardware suspend latching and drain, R7 R9 R10 R11
    for (int c = 0; c < 16; c++) begin
      logic [2:0] p;
      do_reset();
      susp_ni = 0; cyc(); chk_mode(3'd3, "R4");
      p = {c[2] & c[3], c[1], c[0]};
      for (int r = 0; r < 2; r++) begin
        smi_ni = !c[0]; nmi_i = c[1]; intr_i = c[2]; if_i = c[3];
        cyc();
        chk_mode(3'd3, "R7"); chk_pend(p, r == 0 ? "R7" : "R10");
      end
      idle(); cyc();
      chk_mode(3'd0, "R7"); chk_pend(p, "R10");
      drain(p);
    end

    // mgmt latching, R8
    do_reset();
    smint_i = 1; cyc(); smint_i = 0;
    nmi_i = 1; cyc(); nmi_i = 0; chk_mode(3'd4, "R8"); chk_pend(3'b010, "R8");
    susp_ni = 0; cyc(); chk_mode(3'd7, "R4");
    intr_i = 1; smi_ni = 0; cyc(); intr_i = 0; smi_ni = 1;
    chk_mode(3'd7, "R8"); chk_pend(3'b110, "R8");
    susp_ni = 1; cyc(); chk_mode(3'd4, "R8"); chk_pend(3'b110, "R8");
    rsm_i = 1; cyc(); rsm_i = 0; chk_mode(3'd0, "R3"); chk_pend(3'b110, "R8");
    drain(3'b110);

    // pending beats halt in mode 0, R11
    do_reset();
    susp_ni = 0; cyc(); nmi_i = 1; cyc(); idle(); cyc();
    halt_i = 1; cyc(); halt_i = 0;
    chk_mode(3'd1, "R11"); chk_pend(3'b000, "R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule